// File: doc/BRIEF.md
# Display Window Fetch Address Generator

This block produces the word addresses used to read one field of a frame buffer into the display window. Software writes two base addresses and one packed size word. The first base serves the long field and the second serves the short field. The size word holds the window width in 32-bit words, the window height in lines, and a line modulo. The block copies all three into working registers only on a vertical-blank pulse. Panning therefore takes effect cleanly at a field boundary.

The display timing generator drives three strobes: field start, line start and word request. A field start loads the base address of the field named by the parity input. Each word request steps the address by one word, up to the last word of the line. A line start jumps from the last word of the current line to the first word of the next line, a distance equal to the modulo. In progressive scan the modulo is 1. In interlaced scan it is 1 plus the line length in words, which steps over the lines of the other field. After the last line of the window, the valid output goes low and stays low until the next field start.

Top module: `dwin_fetch_addr`

## Requirements
- R1: While reset is asserted and directly after it, `addr_valid` is 0 and `word_addr` is 0.
- R2: The two base addresses and the size word are captured only in a cycle where `vblank` is 1. A change on those inputs in other cycles has no effect on the addresses produced until the next `vblank`. A `field_start` in the same cycle as `vblank` still uses the values captured before that cycle.
- R3: The size word is decoded as follows. Bits [9:0] hold width−1, in 32-bit words. Bits [19:10] hold height−1, in lines. Bits [29:20] hold the modulo.
- R4: A `field_start` loads `word_addr` with the captured long-field base when `field_sel` is 0, or with the short-field base when `field_sel` is 1. It sets `addr_valid` to 1. The result is visible after that clock edge.
- R5: A `word_req` while valid advances `word_addr` by 1, provided the current word is not the last word of the line. A request made on the last word is ignored.
- R6: A `line_start` while valid, on any line except the last, moves `word_addr` to (first address of the current line) + (width−1) + modulo. This holds no matter how many words of the line were requested.
- R7: A `line_start` on the last line of the window (line index height−1) clears `addr_valid` and leaves `word_addr` unchanged. While `addr_valid` is 0, `word_req` and `line_start` change nothing.
- R8: When strobes arrive in the same cycle, `field_start` takes priority over `line_start`, and `line_start` takes priority over `word_req`.
- R9: In a cycle with no strobe, `word_addr` and `addr_valid` keep their values.
- R10: Address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base_long | input | AW | Long-field base word address |
| cfg_base_short | input | AW | Short-field base word address |
| cfg_size | input | MW+HW+WW | Packed modulo, height−1 and width−1 |
| vblank | input | 1 | Capture pulse for the configuration |
| field_start | input | 1 | Start of a field |
| field_sel | input | 1 | 0 selects the long field, 1 selects the short field |
| line_start | input | 1 | End of the current line and start of the next |
| word_req | input | 1 | Request for the next word of the line |
| word_addr | output | AW | Current word address |
| addr_valid | output | 1 | The address belongs to the window |

## Verification
Every result is registered once. A strobe applied before a clock edge shows on `word_addr` and `addr_valid` just after that edge. A configuration change needs one `vblank` edge before a later `field_start` can use it. The bench changes its inputs a quarter period after each rising edge and samples the outputs at that same point. Each check therefore looks at the state produced by exactly the one edge that followed the stimulus. The bench sweeps width, height, modulo and field parity, and the expected addresses are computed from R4 to R7.

// File: rtl/dwin_fetch_addr.sv
module dwin_fetch_addr #(
  parameter int AW = 24,
  parameter int WW = 10,
  parameter int HW = 10,
  parameter int MW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       cfg_base_long,
  input  logic [AW-1:0]       cfg_base_short,
  input  logic [MW+HW+WW-1:0] cfg_size,
  input  logic                vblank,
  input  logic                field_start,
  input  logic                field_sel,
  input  logic                line_start,
  input  logic                word_req,
  output logic [AW-1:0]       word_addr,
  output logic                addr_valid
);
  localparam int H_LSB = WW;
  localparam int M_LSB = WW + HW;
  localparam int SZW   = MW + HW + WW;

  logic [AW-1:0]  sh_long, sh_short, lbase, next_line, fbase;
  logic [SZW-1:0] sh_size;
  logic [WW-1:0]  wcnt, wlast;
  logic [HW-1:0]  lcnt, hlast;
  logic [MW-1:0]  modv;

  assign wlast     = sh_size[WW-1:0];
  assign hlast     = sh_size[H_LSB +: HW];
  assign modv      = sh_size[M_LSB +: MW];
  assign fbase     = field_sel ? sh_short : sh_long;
  assign next_line = lbase + AW'(wlast) + AW'(modv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_long    <= '0;
      sh_short   <= '0;
      sh_size    <= '0;
      word_addr  <= '0;
      lbase      <= '0;
      wcnt       <= '0;
      lcnt       <= '0;
      addr_valid <= 1'b0;
    end else begin
      if (vblank) begin
        sh_long  <= cfg_base_long;
        sh_short <= cfg_base_short;
        sh_size  <= cfg_size;
      end
      if (field_start) begin
        word_addr  <= fbase;
        lbase      <= fbase;
        wcnt       <= '0;
        lcnt       <= '0;
        addr_valid <= 1'b1;
      end else if (addr_valid && line_start) begin
        if (lcnt == hlast) begin
          addr_valid <= 1'b0;
        end else begin
          word_addr <= next_line;
          lbase     <= next_line;
          wcnt      <= '0;
          lcnt      <= lcnt + 1'b1;
        end
      end else if (addr_valid && word_req && wcnt != wlast) begin
        word_addr <= word_addr + 1'b1;
        wcnt      <= wcnt + 1'b1;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> !addr_valid && word_addr == '0); // R1

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> addr_valid && word_addr == $past(field_sel ? sh_short : sh_long)); // R4

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && word_req && !line_start && !field_start && wcnt != wlast
    |=> word_addr == $past(word_addr) + 1'b1); // R5

  AST_LAST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !line_start && !field_start && wcnt == wlast |=> $stable(word_addr)); // R5

  AST_LINE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && line_start && !field_start && lcnt != hlast && wcnt == wlast
    |=> word_addr == $past(word_addr) + AW'($past(modv))); // R6

  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_valid) |-> $past(line_start) && !$past(field_start)); // R7

  AST_IDLE_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid && !field_start |=> !addr_valid && $stable(word_addr)); // R7

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start && !line_start && !word_req |=> $stable(word_addr) && $stable(addr_valid)); // R9
endmodule

// File: tb/tb_dwin_fetch_addr.sv
module tb_dwin_fetch_addr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int SZW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_base_long = '0, cfg_base_short = '0;
  logic [SZW-1:0] cfg_size = '0;
  logic vblank = 0, field_start = 0, field_sel = 0, line_start = 0, word_req = 0;
  logic [AW-1:0] word_addr;
  logic addr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwin_fetch_addr dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_base_long(cfg_base_long), .cfg_base_short(cfg_base_short), .cfg_size(cfg_size),
    .vblank(vblank), .field_start(field_start), .field_sel(field_sel),
    .line_start(line_start), .word_req(word_req),
    .word_addr(word_addr), .addr_valid(addr_valid)
  );

  task automatic chk(input string req, input logic [AW-1:0] ea, input logic ev);
    checks++;
    if (word_addr !== ea || addr_valid !== ev) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b", req, word_addr, addr_valid, ea, ev);
    end
  endtask

  task automatic cyc(input logic vb, input logic fs, input logic fsel, input logic ls, input logic wr);
    vblank = vb; field_start = fs; field_sel = fsel; line_start = ls; word_req = wr;
    @(posedge clk);
    #(CLK_PERIOD/4);
    vblank = 0; field_start = 0; line_start = 0; word_req = 0;
  endtask

  function automatic logic [SZW-1:0] pack(input int m, input int h, input int w);
    return {10'(m), 10'(h - 1), 10'(w - 1)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: addr=%h valid=%b expected addr=x valid=x", word_addr, addr_valid);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] lb, base;
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0);
    chk("R1 after reset", '0, 1'b0);

    // R3 R4 R5 R6 R7 sweep
    for (int mi = 0; mi < 2; mi++) begin
      for (int h = 1; h <= 3; h++) begin
        for (int w = 1; w <= 4; w++) begin
          for (int fs = 0; fs < 2; fs++) begin
            int m;
            m = (mi == 0) ? 1 : 1 + w + 2;
            cfg_base_long  = AW'(24'h001000 + 24'(mi * 256 + h * 32 + w));
            cfg_base_short = cfg_base_long + AW'(w);
            cfg_size = pack(m, h, w);
            cyc(1, 0, 0, 0, 0);
            cyc(0, 1, fs[0], 0, 0);
            base = fs ? cfg_base_short : cfg_base_long;
            chk("R4 field base", base, 1'b1);
            lb = base;
            for (int l = 0; l < h; l++) begin
              for (int k = 1; k <= w; k++) begin
                cyc(0, 0, 0, 0, 1);
                chk("R5 word step", lb + AW'((k < w - 1) ? k : w - 1), 1'b1);
              end
              cyc(0, 0, 0, 0, 0);
              chk("R9 hold", lb + AW'(w - 1), 1'b1);
              cyc(0, 0, 0, 1, 0);
              if (l < h - 1) begin
                lb = lb + AW'(w - 1) + AW'(m);
                chk("R6 line jump R3 modulo", lb, 1'b1);
              end else begin
                chk("R7 valid drop", lb + AW'(w - 1), 1'b0);
              end
            end
            cyc(0, 0, 0, 0, 1);
            chk("R7 word ignored", lb + AW'(w - 1), 1'b0);
            cyc(0, 0, 0, 1, 0);
            chk("R7 line ignored", lb + AW'(w - 1), 1'b0);
          end
        end
      end
    end

    // R6 partial line: width 4, modulo 3, height 3
    cfg_base_long = 24'h004000; cfg_base_short = 24'h005000; cfg_size = pack(3, 3, 4);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R5 one word", 24'h004001, 1'b1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 partial line", 24'h004006, 1'b1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 empty line", 24'h00400C, 1'b1);

    // R2 change without vblank ignored
    cfg_base_long = 24'h007000; cfg_size = pack(1, 1, 1);
    cyc(0, 1, 0, 0, 0);
    chk("R2 old base kept", 24'h004000, 1'b1);
    cyc(0, 0, 0, 0, 1);
    chk("R2 old width kept", 24'h004001, 1'b1);
    cyc(1, 1, 0, 0, 0);
    chk("R2 same-cycle vblank uses old", 24'h004000, 1'b1);
    cyc(0, 1, 0, 0, 0);
    chk("R2 new base", 24'h007000, 1'b1);
    cyc(0, 0, 0, 0, 1);
    chk("R2 new width", 24'h007000, 1'b1);

    // R8 priorities
    cfg_base_long = 24'h00A000; cfg_base_short = 24'h00B000; cfg_size = pack(2, 3, 3);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 1, 1, 1, 1);
    chk("R8 field over line", 24'h00B000, 1'b1);
    cyc(0, 0, 0, 1, 1);
    chk("R8 line over word", 24'h00B004, 1'b1);

    // R10 wrap
    cfg_base_long = 24'hFFFFFE; cfg_size = pack(1, 2, 3);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10 word wrap", 24'h000000, 1'b1);
    cyc(0, 0, 0, 1, 0);
    chk("R10 line wrap", 24'h000001, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule